// File: doc/BRIEF.md
# Triggered Pattern Output Engine

This block plays a stored digital pattern onto a 32-bit output port. Software loads sample words into an external FIFO, picks a pacing source, an output width and the trigger polarity, and then arms the engine. Nothing leaves the port until a qualified edge arrives on the trigger input. From then on, each pacing event moves the next sample to the port. A sample can come from a whole FIFO word, or from one 8-bit or 16-bit slice of a word, with the low slice taken first.

The pacing event is chosen from four sources: a fast internal rate, a half-rate internal rate, an external pacer tick, or the rising edge of the receiver's acknowledge strobe. An optional handshake raises a request line with every new sample. The following sample waits until the receiver acknowledges, so that no data is lost. Without the handshake, the request line gives a one-cycle valid pulse per sample.

In single-pass mode the engine may find the FIFO drained when a sample is due. It then holds the last value on the port and sets a sticky underrun flag. In repeat mode it asks the storage to restart its read pointer instead, and the pattern loops with no end.

Top module: `pattern_out_engine`

## Requirements
- R1: After reset, `dout` is 0 and `dout_req`, `stat_running`, `stat_underrun`, `fifo_rd_en` and `fifo_rewind` are all low.
- R2: Once `cfg_enable` is high, the engine reads no FIFO word and presents no sample until a trigger is accepted. Pacing events that arrive before the trigger produce no output. `stat_running` rises in the cycle after acceptance. Driving `cfg_enable` low returns the engine to idle.
- R3: A trigger is accepted only if the synchronized input changes to the active level and then stays there for `TRIG_MIN_CYC` consecutive clock cycles. The active level is high when `cfg_trig_fall`=0 and low when `cfg_trig_fall`=1. A shorter pulse is ignored.
- R4: `cfg_clk_sel` picks the pacing source. With 0, one sample is presented every `FAST_DIV` cycles. With 1, one sample every `SLOW_DIV` cycles. With 2, one sample per cycle that `pacer_tick` is high. With 3, one sample per rising edge of `ext_ack`.
- R5: `cfg_width` 0 selects 8-bit samples, 1 selects 16-bit samples, and 2 or 3 select 32-bit samples. Each FIFO word is popped once and emitted as 4, 2 or 1 samples, starting with bits [7:0] or [15:0]. The unused upper bits of `dout` are 0.
- R6: With `cfg_handshake`=1, `dout_req` rises together with each new sample. `dout` and `dout_req` then hold until a rising edge of `ext_ack`. `dout_req` falls in the cycle after that edge, and no further sample is presented until after the acknowledge.
- R7: With `cfg_handshake`=0, each new sample on `dout` comes with a `dout_req` pulse that is one cycle wide.
- R8: In single-pass mode, a due sample with no data left sets `stat_underrun` while `dout` holds its last value. The flag stays set, even after the engine is disabled, until `stat_clr_underrun` is applied. Output resumes as soon as the FIFO has data again.
- R9: With `cfg_repeat`=1, an empty FIFO during a run produces a one-cycle `fifo_rewind` pulse in place of an underrun. The sample sequence then continues from the first stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Arms the engine; low forces idle |
| cfg_trig_fall | input | 1 | Trigger active level: 0 high, 1 low |
| cfg_clk_sel | input | 2 | Pacing source: 0 fast, 1 half, 2 pacer tick, 3 ack strobe |
| cfg_width | input | 2 | Sample width: 0 8-bit, 1 16-bit, 2/3 32-bit |
| cfg_handshake | input | 1 | Enables request/acknowledge flow control |
| cfg_repeat | input | 1 | Loops the stored pattern |
| stat_clr_underrun | input | 1 | Clears the underrun flag |
| stat_running | output | 1 | Trigger accepted, pattern output active |
| stat_underrun | output | 1 | Sticky: a sample was due with no data |
| trig_in | input | 1 | Asynchronous start trigger |
| pacer_tick | input | 1 | One-cycle pacing pulse from an external timer |
| ext_ack | input | 1 | Receiver acknowledge / external strobe (synchronous to clk) |
| dout_req | output | 1 | Sample-valid request to the receiver |
| dout | output | 32 | Output data port |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd_data | input | 32 | Head word of the FIFO (first-word fall-through) |
| fifo_rd_en | output | 1 | Pops the head word |
| fifo_rewind | output | 1 | Asks the storage to restart its read pointer |

## Verification
A lane counter that is out of step shows up on the very next sample as a slice of the wrong word, or as a FIFO pop at the wrong point. A pending-step or acknowledge flag that sticks shows up within one pacing period, as a missing sample, a doubled sample, or a request that rises before any acknowledge. A trigger qualifier that counts wrongly either starts the run on a pulse that should be ignored or never starts it, and `stat_running` shows this within a few cycles. An underrun or rewind fault shows up at the first wrap of the stored pattern, on the flag or in the repeated sequence.

// File: rtl/pgen_pkg.sv
// Shared types and helpers for the pattern output engine.
// Assumes a 32-bit FIFO word split into 8/16/32-bit lanes.
package pgen_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        PACE_FAST   = 2'd0,
        PACE_HALF   = 2'd1,
        PACE_TIMER  = 2'd2,
        PACE_STROBE = 2'd3
    } pace_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } eng_state_e;

    // Bits per sample for a width code
    function automatic int lane_bits(input logic [1:0] w);
        case (w)
            2'd0:    return 8;
            2'd1:    return 16;
            default: return WORD_W;
        endcase
    endfunction

    // Samples carried by one FIFO word
    function automatic logic [2:0] lane_count(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd4;
            2'd1:    return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // Mask keeping the low sample of a word
    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] w);
        case (w)
            2'd0:    return {{(WORD_W-8){1'b0}}, 8'hFF};
            2'd1:    return {{(WORD_W-16){1'b0}}, 16'hFFFF};
            default: return {WORD_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/pgen_trig_detect.sv
// Trigger qualifier: two-flop synchronizer, polarity select and a
// minimum-width filter. fire pulses for one cycle once the input has
// moved to its active level and held it for MIN_CYC cycles.
// Assumes trig_in is asynchronous and MIN_CYC >= 1.
module pgen_trig_detect #(
    parameter int MIN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic fall_sel,
    output logic fire
);
    localparam int CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;

    logic          sync1, sync2;
    logic          lvl;
    logic          was_low;
    logic [CW-1:0] hold_cnt;

    // Bring the trigger into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= trig_in;
            sync2 <= sync1;
        end
    end

    assign lvl = sync2 ^ fall_sel;

    // Count cycles at the active level after an inactive phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_low  <= 1'b0;
            hold_cnt <= '0;
            fire     <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!lvl) begin
                was_low  <= 1'b1;
                hold_cnt <= '0;
            end else if (was_low) begin
                if (hold_cnt == CW'(MIN_CYC - 1)) begin
                    fire     <= 1'b1;
                    was_low  <= 1'b0;
                    hold_cnt <= '0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

    a_r3_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(lvl));

endmodule

// File: rtl/pgen_pace_gen.sv
// Pacing source selection. It produces one-cycle tick events from two
// internal dividers, an external pacer pulse or the acknowledge rising
// edge. The dividers restart when a run begins. Assumes pacer_tick and
// ext_ack are synchronous to clk.
module pgen_pace_gen import pgen_pkg::*; #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] sel,
    input  logic       pacer_tick,
    input  logic       ext_ack,
    output logic       tick,
    output logic       ack_rise
);
    localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [FW-1:0] fast_cnt;
    logic [SW-1:0] slow_cnt;
    logic          fast_hit, slow_hit;
    logic          ack_q;

    assign fast_hit = (fast_cnt == FW'(FAST_DIV - 1));
    assign slow_hit = (slow_cnt == SW'(SLOW_DIV - 1));

    // Free-running dividers, realigned at run start
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fast_cnt <= '0;
            slow_cnt <= '0;
        end else begin
            fast_cnt <= fast_hit ? '0 : fast_cnt + 1'b1;
            slow_cnt <= slow_hit ? '0 : slow_cnt + 1'b1;
        end
    end

    // Remember the strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ext_ack;
    end

    assign ack_rise = ext_ack & ~ack_q;

    // Route the selected source onto the tick output
    always_comb begin
        case (sel)
            PACE_FAST:  tick = fast_hit;
            PACE_HALF:  tick = slow_hit;
            PACE_TIMER: tick = pacer_tick;
            default:    tick = ack_rise;
        endcase
    end

    a_r4_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PACE_STROBE && tick) |-> (ext_ack && !$past(ext_ack)));
    a_r4_timer_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PACE_TIMER) |-> (tick == pacer_tick));

endmodule

// File: rtl/pgen_lane_unpack.sv
// Lane unpacker. load takes a fresh FIFO word and emits its low lane;
// adv emits the next lane of the stored word. drained is high when no
// lanes of the stored word remain. Assumes width is steady during a run.
module pgen_lane_unpack import pgen_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [1:0]        width,
    input  logic              load,
    input  logic              adv,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] next_unit,
    output logic              drained
);
    logic [WORD_W-1:0] rest;
    logic [2:0]        left;

    assign drained   = (left == 3'd0);
    assign next_unit = (load ? word_in : rest) & lane_mask(width);

    // Track the unsent lanes of the current word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rest <= '0;
            left <= 3'd0;
        end else if (load) begin
            rest <= word_in >> lane_bits(width);
            left <= lane_count(width) - 3'd1;
        end else if (adv) begin
            rest <= rest >> lane_bits(width);
            left <= left - 3'd1;
        end
    end

    a_r5_pop_only_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (drained && !adv));
    a_r5_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
        left < 3'd4);

endmodule

// File: rtl/pattern_out_engine.sv
// Triggered pattern output engine top. It sequences idle, armed and run,
// serves one sample per pacing event with optional request/acknowledge
// flow control, and handles FIFO drain by underrun or rewind.
// Assumes a first-word fall-through FIFO, a storage that rewinds on the
// cycle after fifo_rewind, and configuration that changes only while
// the engine is idle.
module pattern_out_engine import pgen_pkg::*; #(
    parameter int FAST_DIV     = 2,
    parameter int SLOW_DIV     = 4,
    parameter int TRIG_MIN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_trig_fall,
    input  logic [1:0]        cfg_clk_sel,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_handshake,
    input  logic              cfg_repeat,
    input  logic              stat_clr_underrun,
    output logic              stat_running,
    output logic              stat_underrun,
    input  logic              trig_in,
    input  logic              pacer_tick,
    input  logic              ext_ack,
    output logic              dout_req,
    output logic [WORD_W-1:0] dout,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rd_data,
    output logic              fifo_rd_en,
    output logic              fifo_rewind
);
    eng_state_e        st;
    logic              trig_fire, restart, tick, ack_rise;
    logic              running, due, ack_ok, avail, want, serve, starve;
    logic              drained, rewind_q;
    logic [WORD_W-1:0] next_unit;

    pgen_trig_detect #(.MIN_CYC(TRIG_MIN_CYC)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .fall_sel (cfg_trig_fall),
        .fire     (trig_fire)
    );

    pgen_pace_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .sel        (cfg_clk_sel),
        .pacer_tick (pacer_tick),
        .ext_ack    (ext_ack),
        .tick       (tick),
        .ack_rise   (ack_rise)
    );

    pgen_lane_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!running),
        .width     (cfg_width),
        .load      (serve && drained),
        .adv       (serve && !drained),
        .word_in   (fifo_rd_data),
        .next_unit (next_unit),
        .drained   (drained)
    );

    assign running      = (st == ST_RUN);
    assign stat_running = running;
    assign restart      = (st == ST_ARMED) && trig_fire;
    assign avail        = !drained || !fifo_empty;
    assign want         = running && due && ack_ok;
    assign serve        = want && avail;
    assign starve       = want && !avail && !cfg_repeat;
    assign fifo_rd_en   = serve && drained;
    assign fifo_rewind  = running && cfg_repeat && fifo_empty && !rewind_q;

    // Idle / armed / run sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  st <= ST_ARMED;
                ST_ARMED: if (trig_fire) st <= ST_RUN;
                default:  st <= ST_RUN;
            endcase
        end
    end

    // Pending pacing step and acknowledge/request tracking
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            due      <= 1'b0;
            ack_ok   <= 1'b1;
            dout_req <= 1'b0;
        end else begin
            due <= (due && !serve) || tick;
            if (!cfg_handshake) begin
                ack_ok   <= 1'b1;
                dout_req <= serve;
            end else if (serve) begin
                ack_ok   <= 1'b0;
                dout_req <= 1'b1;
            end else if (ack_rise) begin
                ack_ok   <= 1'b1;
                dout_req <= 1'b0;
            end
        end
    end

    // Output data register, holds between samples
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (serve) dout <= next_unit;
    end

    // Sticky underrun flag, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || stat_clr_underrun) stat_underrun <= 1'b0;
        else if (starve)                 stat_underrun <= 1'b1;
    end

    // Space rewind requests so storage can respond
    always_ff @(posedge clk) begin
        if (!rst_n) rewind_q <= 1'b0;
        else        rewind_q <= fifo_rewind;
    end

    a_r2_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_running |-> !fifo_rd_en);
    a_r2_start_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_running) |-> $past(trig_fire));
    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);
    a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && cfg_width == 2'd0) |=> (dout[WORD_W-1:8] == '0));
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_handshake && dout_req && !ack_rise && stat_running) |=> ($stable(dout) && dout_req));
    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_underrun && !stat_clr_underrun) |=> stat_underrun);
    a_r9_rewind_only_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rewind |-> (cfg_repeat && stat_running));

endmodule

// File: tb/sim_pattern_out_engine.sv
module sim_pattern_out_engine;
    localparam int CLK_PERIOD = 10;
    localparam int FAST_DIV   = 2;
    localparam int SLOW_DIV   = 4;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_trig_fall = 1'b0;
    logic [1:0]  cfg_clk_sel = 2'd0, cfg_width = 2'd2;
    logic        cfg_handshake = 1'b0, cfg_repeat = 1'b0, stat_clr_underrun = 1'b0;
    logic        stat_running, stat_underrun;
    logic        trig_in = 1'b0, pacer_tick = 1'b0;
    logic        ack_auto_v = 1'b0, ack_man_v = 1'b0, ack_auto_en = 1'b0;
    logic        ext_ack;
    logic        dout_req;
    logic [31:0] dout;
    logic        fifo_empty, fifo_rd_en, fifo_rewind;
    logic [31:0] fifo_rd_data;

    // FIFO storage model
    logic [31:0] mem [0:63];
    int          st_n = 0, st_ptr = 0, pops = 0;
    logic        st_clr = 1'b0;

    // monitor state
    logic [31:0] rec_val [0:255];
    int          rec_cyc [0:255];
    int          rec_ack [0:255];
    int          rec_n = 0, ack_cnt = 0, stab_err = 0, cyc = 0;
    logic        mon_clr = 1'b0, req_prev = 1'b0, ackp = 1'b0;
    logic [31:0] dout_prev = '0;

    int  checks = 0, errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ext_ack      = ack_auto_v | ack_man_v;
    assign fifo_empty   = (st_ptr >= st_n);
    assign fifo_rd_data = (st_ptr < st_n) ? mem[st_ptr] : 32'h0;

    pattern_out_engine #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .TRIG_MIN_CYC(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_trig_fall(cfg_trig_fall),
        .cfg_clk_sel(cfg_clk_sel), .cfg_width(cfg_width), .cfg_handshake(cfg_handshake),
        .cfg_repeat(cfg_repeat), .stat_clr_underrun(stat_clr_underrun),
        .stat_running(stat_running), .stat_underrun(stat_underrun), .trig_in(trig_in),
        .pacer_tick(pacer_tick), .ext_ack(ext_ack), .dout_req(dout_req), .dout(dout),
        .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
        .fifo_rewind(fifo_rewind));

    always @(posedge clk) begin
        if (st_clr)           begin st_ptr <= 0; pops <= 0; end
        else if (fifo_rewind) st_ptr <= 0;
        else if (fifo_rd_en)  begin st_ptr <= st_ptr + 1; pops <= pops + 1; end
    end

    // sample just after each edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (mon_clr) begin
            rec_n = 0; ack_cnt = 0; stab_err = 0;
        end else begin
            if (ext_ack && !ackp) ack_cnt = ack_cnt + 1;
            if (dout_req && !req_prev && rec_n < 256) begin
                rec_val[rec_n] = dout; rec_cyc[rec_n] = cyc; rec_ack[rec_n] = ack_cnt;
                rec_n = rec_n + 1;
            end
            if (cfg_handshake && req_prev && dout_req && dout != dout_prev)
                stab_err = stab_err + 1;
        end
        ackp = ext_ack; req_prev = dout_req; dout_prev = dout;
    end

    // automatic receiver for handshake tests
    initial begin
        forever begin
            @(negedge clk);
            if (ack_auto_en && dout_req) begin
                repeat ($urandom % 5) @(negedge clk);
                ack_auto_v = 1'b1;
                @(negedge clk);
                ack_auto_v = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_unit(input logic [31:0] w, input int width, input int k);
        case (width)
            0:       return (w >> (8 * k)) & 32'hFF;
            1:       return (w >> (16 * k)) & 32'hFFFF;
            default: return w;
        endcase
    endfunction

    function automatic int units_of(input int width);
        return (width == 0) ? 4 : (width == 1) ? 2 : 1;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input int n, input bit rnd);
        for (int i = 0; i < n; i++)
            mem[i] = rnd ? $urandom : (32'hA0B1C2D3 + 32'h01010101 * i);
        st_n = n;
    endtask

    task automatic pulse_trig(input int len);
        trig_in = ~cfg_trig_fall;
        cycles(len);
        trig_in = cfg_trig_fall;
    endtask

    task automatic setup(input int w, input int sel, input bit hs, input bit rep);
        cfg_width = 2'(w); cfg_clk_sel = 2'(sel); cfg_handshake = hs; cfg_repeat = rep;
        st_clr = 1'b1; mon_clr = 1'b1; stat_clr_underrun = 1'b1;
        cycles(1);
        st_clr = 1'b0; mon_clr = 1'b0; stat_clr_underrun = 1'b0;
        cfg_enable = 1'b1;
        cycles(2);
    endtask

    task automatic stop_run();
        cfg_enable = 1'b0;
        cycles(3);
    endtask

    task automatic wait_recs(input int k, input int lim);
        for (int i = 0; i < lim; i++) begin
            if (rec_n >= k) break;
            cycles(1);
        end
    endtask

    task automatic check_seq(input int n_words, input int w, input string req);
        int u;
        u = units_of(w);
        chk(rec_n == n_words * u, req, "sample count", rec_n, n_words * u);
        for (int i = 0; i < n_words * u && i < rec_n; i++)
            chk(rec_val[i] == exp_unit(mem[i / u], w, i % u), req, "sample value",
                rec_val[i], exp_unit(mem[i / u], w, i % u));
        chk(pops == n_words, "R5", "FIFO pops", pops, n_words);
    endtask

    task automatic check_gap(input int gap, input string req);
        int bad;
        bad = 0;
        for (int i = 1; i < rec_n; i++)
            if (rec_cyc[i] - rec_cyc[i-1] != gap) bad++;
        chk(bad == 0, req, "sample spacing mismatches", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd7301));
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        chk(dout == 32'h0, "R1", "dout", dout, 0);
        chk(!dout_req && !stat_running && !stat_underrun, "R1", "flags",
            {dout_req, stat_running, stat_underrun}, 0);
        chk(!fifo_rd_en && !fifo_rewind, "R1", "fifo controls", {fifo_rd_en, fifo_rewind}, 0);

        // R3 short pulse ignored, R2 nothing before trigger
        fill(6, 1'b0);
        setup(2, 0, 1'b0, 1'b0);
        pulse_trig(1);
        cycles(12);
        chk(!stat_running, "R3", "running after short pulse", stat_running, 0);
        chk(rec_n == 0 && pops == 0, "R2", "output before trigger", rec_n + pops, 0);
        pulse_trig(4);
        cycles(6);
        chk(stat_running, "R2", "running after trigger", stat_running, 1);
        // R4 fast rate, R5 32-bit
        wait_recs(6, 100);
        cycles(4);
        check_seq(6, 2, "R5");
        check_gap(FAST_DIV, "R4");
        chk(rec_cyc[1] - rec_cyc[0] == FAST_DIV, "R7", "pulse sample gap", rec_cyc[1] - rec_cyc[0], FAST_DIV);
        // R8 underrun, hold, resume, sticky
        chk(stat_underrun, "R8", "underrun set", stat_underrun, 1);
        chk(dout == mem[5], "R8", "dout held", dout, mem[5]);
        mem[6] = 32'h5EED_0006; st_n = 7;
        cycles(8);
        chk(rec_n == 7 && rec_val[6] == 32'h5EED_0006, "R8", "resume after refill", rec_val[6], 32'h5EED_0006);
        stop_run();
        chk(!stat_running, "R2", "disable returns idle", stat_running, 0);
        chk(stat_underrun, "R8", "sticky after disable", stat_underrun, 1);
        stat_clr_underrun = 1'b1; cycles(1); stat_clr_underrun = 1'b0; cycles(1);
        chk(!stat_underrun, "R8", "cleared", stat_underrun, 0);

        // R4 half rate, R5 16-bit unpack
        fill(4, 1'b0);
        setup(1, 1, 1'b0, 1'b0);
        pulse_trig(4);
        wait_recs(8, 200);
        cycles(10);
        check_seq(4, 1, "R5");
        check_gap(SLOW_DIV, "R4");
        stop_run();

        // R5 8-bit unpack, upper bits zero
        fill(3, 1'b1);
        setup(0, 0, 1'b0, 1'b0);
        pulse_trig(4);
        wait_recs(12, 200);
        cycles(6);
        check_seq(3, 0, "R5");
        chk(dout[31:8] == 0, "R5", "upper bits in 8-bit mode", dout[31:8], 0);
        stop_run();

        // R3 falling polarity
        trig_in = 1'b1; cycles(6);
        cfg_trig_fall = 1'b1; cycles(4);
        fill(2, 1'b0);
        setup(2, 0, 1'b0, 1'b0);
        cycles(8);
        chk(!stat_running, "R3", "no start on idle-high with falling", stat_running, 0);
        pulse_trig(4);
        cycles(6);
        chk(stat_running, "R3", "start on falling edge", stat_running, 1);
        stop_run();
        trig_in = 1'b0; cycles(6);
        cfg_trig_fall = 1'b0; cycles(4);

        // R4 pacer tick source
        fill(8, 1'b1);
        setup(2, 2, 1'b0, 1'b0);
        pulse_trig(4);
        cycles(6);
        for (int i = 0; i < 5; i++) begin
            pacer_tick = 1'b1; cycles(1); pacer_tick = 1'b0; cycles(6);
        end
        cycles(4);
        chk(rec_n == 5, "R4", "samples per pacer tick", rec_n, 5);
        check_gap(7, "R4");
        stop_run();

        // R4 strobe source, R2 strobes before trigger ignored
        fill(8, 1'b1);
        setup(2, 3, 1'b0, 1'b0);
        for (int i = 0; i < 2; i++) begin
            ack_man_v = 1'b1; cycles(1); ack_man_v = 1'b0; cycles(3);
        end
        chk(rec_n == 0, "R2", "strobe before trigger", rec_n, 0);
        pulse_trig(4);
        cycles(6);
        for (int i = 0; i < 5; i++) begin
            ack_man_v = 1'b1; cycles(1); ack_man_v = 1'b0; cycles(2 + $urandom % 5);
        end
        cycles(4);
        chk(rec_n == 5, "R4", "samples per strobe edge", rec_n, 5);
        chk(rec_val[4] == mem[4], "R4", "strobe sample value", rec_val[4], mem[4]);
        stop_run();

        // R6 handshake: holds without ack, then flows with ack
        fill(5, 1'b1);
        setup(2, 0, 1'b1, 1'b0);
        pulse_trig(4);
        cycles(30);
        chk(rec_n == 1 && dout_req, "R6", "waits for ack", rec_n, 1);
        chk(dout == mem[0], "R6", "held value", dout, mem[0]);
        ack_auto_en = 1'b1;
        wait_recs(5, 300);
        cycles(20);
        ack_auto_en = 1'b0;
        check_seq(5, 2, "R6");
        chk(stab_err == 0, "R6", "dout changed while req high", stab_err, 0);
        for (int i = 0; i < rec_n; i++)
            chk(rec_ack[i] == i, "R6", "acks before sample", rec_ack[i], i);
        stop_run();

        // R9 repeat loops with no underrun
        fill(3, 1'b1);
        setup(2, 0, 1'b0, 1'b1);
        pulse_trig(4);
        wait_recs(10, 200);
        for (int i = 0; i < 10; i++)
            chk(rec_val[i] == mem[i % 3], "R9", "looped sample", rec_val[i], mem[i % 3]);
        chk(!stat_underrun, "R9", "no underrun in repeat", stat_underrun, 0);
        check_gap(FAST_DIV, "R9");
        stop_run();

        // random mix of widths, rates and handshake
        for (int t = 0; t < 8; t++) begin
            int w, sel, n;
            bit hs;
            w = $urandom % 3; sel = $urandom % 2; hs = 1'($urandom % 2); n = 1 + $urandom % 6;
            fill(n, 1'b1);
            ack_auto_en = hs;
            setup(w, sel, hs, 1'b0);
            pulse_trig(2 + $urandom % 3);
            wait_recs(n * units_of(w), 2000);
            cycles(20);
            check_seq(n, w, hs ? "R6" : "R5");
            if (!hs) check_gap(sel == 0 ? FAST_DIV : SLOW_DIV, "R4");
            ack_auto_en = 1'b0;
            stop_run();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule